// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block keeps a small circular set of receive slots shared between a network device model and a host-side consumer. Each slot has a 32-bit status word and its own frame buffer. The device side fills a buffer and then writes the slot's status word. The host side walks the ring from a tail index. It can ask whether the tail slot holds a frame, or it can ask the block to take that frame.

On a take, the block reports the frame length. It then streams the buffer out as bytes over a valid/ready channel and marks the final byte. After the last byte is accepted, it gives the slot back to the device and moves the tail on. A frame whose status carries the error flag is recycled on the spot and never streamed. A descriptor read port shows the status, control word and buffer size of any slot, so the host can inspect the ring.

Top module: `rxr_ring_consumer`

## Requirements
- R1: After reset, every slot's status reads 0x80000000, its control word reads 0x4 and its buffer size reads 1536. The tail is 0, `proto_err` is 0, `host_req_ready` is 1 and `out_valid` is 0.
- R2: Status bit 31 set means the device owns the slot. When the tail slot is device-owned, a query or a take answers `rsp_avail`=0 and `rsp_dropped`=0, starts no stream and leaves the tail unchanged.
- R3: A query (`host_req_retrieve`=0) on a host-owned tail slot answers `rsp_avail`=1, with `rsp_len` taken from status bits 29:16. The tail and every status word stay unchanged.
- R4: A take on a host-owned, error-free tail slot answers `rsp_avail`=1 and `rsp_len`. It then streams `rsp_len` bytes. Byte k is byte lane k mod 4 (lane 0 = bits 7:0) of buffer word k/4, and `out_last` is high only with byte `rsp_len`-1.
- R5: When the final byte is accepted, the slot's status becomes 0x80000000 and the tail advances by one, wrapping from 3 to 0.
- R6: A take on a host-owned tail slot whose status bit 15 is set answers `rsp_avail`=0 and `rsp_dropped`=1, and it streams nothing. In the same cycle the slot's status becomes 0x80000000 and the tail advances.
- R7: A length field above 1536 is clamped to 1536, both in `rsp_len` and in the number of bytes streamed. A take with a length of 0 answers `rsp_avail`=1 and `rsp_len`=0, streams nothing, and returns the slot and advances the tail at once.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady. No request is accepted while a stream is in progress (`host_req_ready`=0).
- R9: A device status write or buffer write to a host-owned slot is ignored, and it sets `proto_err`, which stays high until reset.
- R10: `rsp_valid` is high for exactly the one cycle after each accepted request, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_stat_we | input | 1 | Device writes a slot status word |
| dev_stat_slot | input | 2 | Slot addressed by the status write |
| dev_stat_data | input | 32 | Status value written by the device |
| dev_buf_we | input | 1 | Device writes a buffer word |
| dev_buf_slot | input | 2 | Slot addressed by the buffer write |
| dev_buf_addr | input | 9 | Word index within the slot buffer |
| dev_buf_data | input | 32 | Buffer word, byte lane 0 in bits 7:0 |
| host_req_valid | input | 1 | Host request strobe |
| host_req_retrieve | input | 1 | 1 = take frame, 0 = query only |
| host_req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_avail | output | 1 | Frame available / delivered |
| rsp_dropped | output | 1 | Errored frame was recycled |
| rsp_len | output | 14 | Clamped frame length of the tail slot |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Consumer accepts the stream byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |
| tail_slot | output | 2 | Current tail index |
| proto_err | output | 1 | Sticky illegal-device-write flag |
| desc_rd_slot | input | 2 | Slot selected for descriptor read |
| desc_rd_status | output | 32 | Status word of the selected slot |
| desc_rd_ctrl | output | 32 | Control word of the selected slot |
| desc_rd_bufsz | output | 14 | Buffer size of the selected slot |

## Verification
The bound checker watches the stream handshake and the request/response timing on every cycle. It checks that bytes hold under stall, that `out_last` only comes with a valid byte, that no request is accepted mid-stream, and that a response follows exactly one cycle after each accepted request. It also checks that the tail only ever steps by one with wrap, that queries leave it alone, and that `proto_err` never clears. Byte contents and order, length clamping, error drops, slot return values and the ignoring of illegal device writes can only be shown by the bench's scenarios, which compare against patterns computed in the bench.

// File: rtl/rxr_pkg.sv
// Package: shared constants and types for the receive ring consumer.
// Assumes 32-bit status words laid out with ownership, length and error fields.
package rxr_pkg;
    localparam int STAT_W      = 32;
    localparam int OWN_BIT     = 31;
    localparam int ERR_BIT     = 15;
    localparam int LEN_LO      = 16;
    localparam int LEN_W       = 14;
    localparam logic [STAT_W-1:0] STAT_RETURNED  = 32'h8000_0000;
    localparam logic [STAT_W-1:0] CTRL_CHAINED   = 32'h0000_0004;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } stream_st_t;
endpackage

// File: rtl/rxr_desc_table.sv
// Descriptor status table: one status register per slot.
// Device writes land only on device-owned slots; the host returns slots by
// forcing them to the returned value. Any device write aimed at a host-owned
// slot is dropped and latches a sticky protocol error.
module rxr_desc_table
    import rxr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               dev_we,
    input  logic [SLOT_W-1:0]                  dev_slot,
    input  logic [STAT_W-1:0]                  dev_data,
    input  logic                               dev_buf_we,
    input  logic [SLOT_W-1:0]                  dev_buf_slot,
    input  logic                               ret_we,
    input  logic [SLOT_W-1:0]                  ret_slot,
    output logic [NUM_SLOTS-1:0][STAT_W-1:0]   stat_q,
    output logic                               proto_err
);
    logic stat_bad;
    logic buf_bad;

    // Flag device writes whose target slot is currently host-owned.
    always_comb begin
        stat_bad = dev_we     && !stat_q[dev_slot][OWN_BIT];
        buf_bad  = dev_buf_we && !stat_q[dev_buf_slot][OWN_BIT];
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Per-slot status: reset to device-owned, host return, guarded device write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[i] <= STAT_RETURNED;
            end else if (ret_we && ret_slot == SLOT_W'(i)) begin
                stat_q[i] <= STAT_RETURNED;
            end else if (dev_we && dev_slot == SLOT_W'(i) && stat_q[i][OWN_BIT]) begin
                stat_q[i] <= dev_data;
            end
        end
    end

    // Sticky protocol error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else if (stat_bad || buf_bad) begin
            proto_err <= 1'b1;
        end
    end
endmodule

// File: rtl/rxr_buf_mem.sv
// Frame buffer storage: one word-wide buffer per slot, written by the device
// one word at a time and read asynchronously by the stream controller.
// Assumes the caller has already gated writes for ownership and range.
module rxr_buf_mem #(
    parameter int NUM_SLOTS = 4,
    parameter int WORDS     = 384,
    parameter int SLOT_W    = 2,
    parameter int WADDR_W   = 9
) (
    input  logic               clk,
    input  logic               we,
    input  logic [SLOT_W-1:0]  wslot,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [31:0]        wdata,
    input  logic [SLOT_W-1:0]  rslot,
    input  logic [WADDR_W-1:0] raddr,
    output logic [31:0]        rdata
);
    logic [31:0] mem_q [NUM_SLOTS][WORDS];

    // Word write from the device side.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wslot][waddr] <= wdata;
        end
    end

    // Asynchronous read for the byte stream.
    always_comb begin
        rdata = mem_q[rslot][raddr];
    end
endmodule

// File: rtl/rxr_stream_ctrl.sv
// Host-side controller: owns the tail index, answers queries and takes,
// drops errored frames, and sequences the byte read-out of a taken frame.
// Assumes the tail slot status fields are presented combinationally.
module rxr_stream_ctrl
    import rxr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int BUF_BYTES = 1536,
    parameter int SLOT_W    = 2,
    parameter int WADDR_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_retrieve,
    output logic               req_ready,
    input  logic               tail_dev_owned,
    input  logic               tail_err,
    input  logic [LEN_W-1:0]   tail_len_field,
    output logic               rsp_valid,
    output logic               rsp_avail,
    output logic               rsp_dropped,
    output logic [LEN_W-1:0]   rsp_len,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_last,
    output logic [WADDR_W-1:0] word_addr,
    output logic [1:0]         byte_lane,
    output logic [SLOT_W-1:0]  tail,
    output logic               ret_we
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_BYTES);

    stream_st_t       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] eff_len;
    logic             accept, host_owned, take, instant_ret, start_stream;
    logic             byte_fire, final_byte;

    // Request decode, length clamp and slot-return conditions.
    always_comb begin
        host_owned   = !tail_dev_owned;
        eff_len      = (tail_len_field > MAX_LEN) ? MAX_LEN : tail_len_field;
        req_ready    = (state_q == ST_IDLE);
        accept       = req_valid && req_ready;
        take         = accept && req_retrieve && host_owned;
        instant_ret  = take && (tail_err || eff_len == '0);
        start_stream = take && !tail_err && eff_len != '0;
        out_valid    = (state_q == ST_STREAM);
        out_last     = out_valid && (cnt_q == len_q - 1'b1);
        byte_fire    = out_valid && out_ready;
        final_byte   = byte_fire && out_last;
        ret_we       = instant_ret || final_byte;
        word_addr    = cnt_q[WADDR_W+1:2];
        byte_lane    = cnt_q[1:0];
    end

    // Stream state, byte counter, latched length and tail pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            tail    <= '0;
        end else begin
            if (start_stream) begin
                state_q <= ST_STREAM;
                cnt_q   <= '0;
                len_q   <= eff_len;
            end else if (final_byte) begin
                state_q <= ST_IDLE;
            end else if (byte_fire) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (ret_we) begin
                tail <= (tail == SLOT_W'(NUM_SLOTS - 1)) ? '0 : tail + 1'b1;
            end
        end
    end

    // One-cycle response registered from the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_avail   <= 1'b0;
            rsp_dropped <= 1'b0;
            rsp_len     <= '0;
        end else begin
            rsp_valid   <= accept;
            rsp_avail   <= accept && host_owned && (!req_retrieve || !tail_err);
            rsp_dropped <= take && tail_err;
            rsp_len     <= (accept && host_owned) ? eff_len : '0;
        end
    end
endmodule

// File: rtl/rxr_ring_consumer.sv
// Top: receive descriptor ring consumer. Joins the status table, the frame
// buffers and the host-side stream controller, and exposes a descriptor
// read port. Assumes a single clock and synchronous active-low reset.
module rxr_ring_consumer
    import rxr_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    parameter  int BUF_BYTES = 1536,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int WORDS     = BUF_BYTES / 4,
    localparam int WADDR_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dev_stat_we,
    input  logic [SLOT_W-1:0]  dev_stat_slot,
    input  logic [31:0]        dev_stat_data,
    input  logic               dev_buf_we,
    input  logic [SLOT_W-1:0]  dev_buf_slot,
    input  logic [WADDR_W-1:0] dev_buf_addr,
    input  logic [31:0]        dev_buf_data,
    input  logic               host_req_valid,
    input  logic               host_req_retrieve,
    output logic               host_req_ready,
    output logic               rsp_valid,
    output logic               rsp_avail,
    output logic               rsp_dropped,
    output logic [LEN_W-1:0]   rsp_len,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_last,
    output logic [SLOT_W-1:0]  tail_slot,
    output logic               proto_err,
    input  logic [SLOT_W-1:0]  desc_rd_slot,
    output logic [31:0]        desc_rd_status,
    output logic [31:0]        desc_rd_ctrl,
    output logic [LEN_W-1:0]   desc_rd_bufsz
);
    logic [NUM_SLOTS-1:0][STAT_W-1:0] stat_q;
    logic                             ret_we;
    logic                             buf_ok;
    logic [WADDR_W-1:0]               rd_word_addr;
    logic [1:0]                       rd_lane;
    logic [31:0]                      rd_word;
    logic [31:0]                      tail_stat;

    // Gate buffer writes to device-owned slots and in-range words.
    always_comb begin
        buf_ok    = dev_buf_we && stat_q[dev_buf_slot][OWN_BIT] && (int'(dev_buf_addr) < WORDS);
        tail_stat = stat_q[tail_slot];
    end

    rxr_desc_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) desc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_we       (dev_stat_we),
        .dev_slot     (dev_stat_slot),
        .dev_data     (dev_stat_data),
        .dev_buf_we   (dev_buf_we),
        .dev_buf_slot (dev_buf_slot),
        .ret_we       (ret_we),
        .ret_slot     (tail_slot),
        .stat_q       (stat_q),
        .proto_err    (proto_err)
    );

    rxr_buf_mem #(.NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .SLOT_W(SLOT_W), .WADDR_W(WADDR_W)) mem_i (
        .clk   (clk),
        .we    (buf_ok),
        .wslot (dev_buf_slot),
        .waddr (dev_buf_addr),
        .wdata (dev_buf_data),
        .rslot (tail_slot),
        .raddr (rd_word_addr),
        .rdata (rd_word)
    );

    rxr_stream_ctrl #(.NUM_SLOTS(NUM_SLOTS), .BUF_BYTES(BUF_BYTES), .SLOT_W(SLOT_W), .WADDR_W(WADDR_W)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (host_req_valid),
        .req_retrieve   (host_req_retrieve),
        .req_ready      (host_req_ready),
        .tail_dev_owned (tail_stat[OWN_BIT]),
        .tail_err       (tail_stat[ERR_BIT]),
        .tail_len_field (tail_stat[LEN_LO +: LEN_W]),
        .rsp_valid      (rsp_valid),
        .rsp_avail      (rsp_avail),
        .rsp_dropped    (rsp_dropped),
        .rsp_len        (rsp_len),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_last       (out_last),
        .word_addr      (rd_word_addr),
        .byte_lane      (rd_lane),
        .tail           (tail_slot),
        .ret_we         (ret_we)
    );

    // Byte lane select and descriptor read port.
    always_comb begin
        out_data       = rd_word[{rd_lane, 3'b000} +: 8];
        desc_rd_status = stat_q[desc_rd_slot];
        desc_rd_ctrl   = CTRL_CHAINED;
        desc_rd_bufsz  = LEN_W'(BUF_BYTES);
    end
endmodule

// File: rtl/rxr_ring_consumer_chk.sv
// Checker: cycle-level properties of the ring consumer's ports, bound to the top.
module rxr_ring_consumer_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req_valid,
    input logic              host_req_retrieve,
    input logic              host_req_ready,
    input logic              rsp_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic [SLOT_W-1:0] tail_slot,
    input logic              proto_err
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    assert_last_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_busy_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !host_req_ready);

    assert_rsp_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req_valid && host_req_ready) |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req_valid && host_req_ready) |=> !rsp_valid);

    assert_query_keeps_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req_valid && host_req_ready && !host_req_retrieve) |=> $stable(tail_slot));

    assert_tail_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_slot != $past(tail_slot)) |->
            (tail_slot == (($past(tail_slot) == LAST_SLOT) ? '0 : $past(tail_slot) + 1'b1)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind rxr_ring_consumer rxr_ring_consumer_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .host_req_valid    (host_req_valid),
    .host_req_retrieve (host_req_retrieve),
    .host_req_ready    (host_req_ready),
    .rsp_valid         (rsp_valid),
    .out_valid         (out_valid),
    .out_ready         (out_ready),
    .out_data          (out_data),
    .out_last          (out_last),
    .tail_slot         (tail_slot),
    .proto_err         (proto_err)
);

// File: tb/rxr_ring_consumer_tb_top.sv
// Bench: sweeps frame lengths around the ring, with drops, empty slots,
// clamping and illegal device writes; expected bytes come from a bench pattern.
module rxr_ring_consumer_tb_top;
    localparam int NS = 4;
    localparam int BB = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_stat_we = 1'b0;
    logic [1:0]  dev_stat_slot = '0;
    logic [31:0] dev_stat_data = '0;
    logic        dev_buf_we = 1'b0;
    logic [1:0]  dev_buf_slot = '0;
    logic [8:0]  dev_buf_addr = '0;
    logic [31:0] dev_buf_data = '0;
    logic        host_req_valid = 1'b0;
    logic        host_req_retrieve = 1'b0;
    logic        host_req_ready;
    logic        rsp_valid, rsp_avail, rsp_dropped;
    logic [13:0] rsp_len;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic [1:0]  tail_slot;
    logic        proto_err;
    logic [1:0]  desc_rd_slot = '0;
    logic [31:0] desc_rd_status, desc_rd_ctrl;
    logic [13:0] desc_rd_bufsz;

    int checks = 0;
    int errors = 0;
    int exp_tail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxr_ring_consumer dut_i (
        .clk(clk), .rst_n(rst_n),
        .dev_stat_we(dev_stat_we), .dev_stat_slot(dev_stat_slot), .dev_stat_data(dev_stat_data),
        .dev_buf_we(dev_buf_we), .dev_buf_slot(dev_buf_slot), .dev_buf_addr(dev_buf_addr),
        .dev_buf_data(dev_buf_data),
        .host_req_valid(host_req_valid), .host_req_retrieve(host_req_retrieve),
        .host_req_ready(host_req_ready),
        .rsp_valid(rsp_valid), .rsp_avail(rsp_avail), .rsp_dropped(rsp_dropped), .rsp_len(rsp_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .tail_slot(tail_slot), .proto_err(proto_err),
        .desc_rd_slot(desc_rd_slot), .desc_rd_status(desc_rd_status),
        .desc_rd_ctrl(desc_rd_ctrl), .desc_rd_bufsz(desc_rd_bufsz)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int slot, input int w);
        return {8'(slot * 37 + 5), 8'(w), 8'(w >> 8) ^ 8'hC3, 8'(w * 7 + slot)};
    endfunction

    function automatic logic [7:0] exp_byte(input int slot, input int k);
        logic [31:0] wv;
        wv = pat(slot, k / 4);
        return wv[8 * (k % 4) +: 8];
    endfunction

    task automatic dev_status(input int slot, input logic [31:0] val);
        @(negedge clk);
        dev_stat_we = 1'b1; dev_stat_slot = 2'(slot); dev_stat_data = val;
        @(posedge clk); #1 dev_stat_we = 1'b0;
    endtask

    task automatic dev_word(input int slot, input int w, input logic [31:0] val);
        @(negedge clk);
        dev_buf_we = 1'b1; dev_buf_slot = 2'(slot); dev_buf_addr = 9'(w); dev_buf_data = val;
        @(posedge clk); #1 dev_buf_we = 1'b0;
    endtask

    task automatic fill(input int slot, input int nbytes);
        for (int w = 0; w < (nbytes + 3) / 4; w++) dev_word(slot, w, pat(slot, w));
    endtask

    // Issue one request; returns at the negedge where the response is visible.
    task automatic request(input bit retr);
        @(negedge clk);
        host_req_valid = 1'b1; host_req_retrieve = retr;
        @(posedge clk); #1 host_req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_status(input int slot, output logic [31:0] st);
        desc_rd_slot = 2'(slot); #0.5;
        st = desc_rd_status;
    endtask

    // Consume len bytes from slot, stalling on some bytes; ends at a negedge.
    task automatic consume(input int slot, input int len);
        for (int k = 0; k < len; k++) begin
            if (k % 5 == 2) begin
                logic [7:0] d0;
                d0 = out_data;
                @(negedge clk);
                chk(out_valid && out_data == d0, "R8", "byte held under stall", out_data, d0);
                chk(!host_req_ready, "R8", "ready low mid-stream", host_req_ready, 0);
            end
            chk(out_valid && out_data == exp_byte(slot, k), "R4", "stream byte",
                out_data, exp_byte(slot, k));
            chk(out_last == (k == len - 1), "R4", "last flag", out_last, (k == len - 1));
            out_ready = 1'b1;
            @(posedge clk); #1 out_ready = 1'b0;
            @(negedge clk);
        end
        chk(!out_valid, "R4", "stream ends after last", out_valid, 0);
    endtask

    task automatic check_returned(input int slot, input string req);
        logic [31:0] st;
        read_status(slot, st);
        chk(st == 32'h8000_0000, req, "slot status returned", st, 32'h8000_0000);
        chk(int'(tail_slot) == exp_tail, req, "tail advanced", tail_slot, exp_tail);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int lens [10] = '{1, 2, 3, 4, 5, 7, 64, 1536, 2000, 13};
        logic [31:0] st;
        int slot, eff;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every slot and of the host side
        for (int s = 0; s < NS; s++) begin
            read_status(s, st);
            chk(st == 32'h8000_0000, "R1", "reset status", st, 32'h8000_0000);
            chk(desc_rd_ctrl == 32'h4, "R1", "control word", desc_rd_ctrl, 4);
            chk(desc_rd_bufsz == 14'(BB), "R1", "buffer size", desc_rd_bufsz, BB);
        end
        chk(tail_slot == 0 && !proto_err, "R1", "tail/proto_err", {tail_slot, proto_err}, 0);
        chk(host_req_ready && !out_valid, "R1", "ready/idle", {host_req_ready, out_valid}, 2);

        // R2: device-owned tail slot, including a device write that keeps ownership
        dev_status(0, 32'h8005_0000);
        request(1'b0);
        chk(rsp_valid && !rsp_avail, "R2", "query on owned slot", {rsp_valid, rsp_avail}, 2);
        @(negedge clk);
        chk(!rsp_valid, "R10", "response is one cycle", rsp_valid, 0);
        request(1'b1);
        chk(rsp_valid && !rsp_avail && !rsp_dropped, "R2", "take on owned slot",
            {rsp_valid, rsp_avail, rsp_dropped}, 4);
        chk(!out_valid && tail_slot == 0, "R2", "no stream, tail kept", {out_valid, tail_slot}, 0);

        // R3/R4/R5/R7: length sweep around the ring, wrapping the tail
        foreach (lens[i]) begin
            slot = exp_tail;
            eff  = (lens[i] > BB) ? BB : lens[i];
            fill(slot, eff);
            dev_status(slot, {2'b00, 14'(lens[i]), 16'h0000});
            request(1'b0);
            chk(rsp_valid && rsp_avail && rsp_len == 14'(eff), "R3", "query length", rsp_len, eff);
            chk(int'(tail_slot) == exp_tail, "R3", "query keeps tail", tail_slot, exp_tail);
            read_status(slot, st);
            chk(st[31] == 1'b0, "R3", "query keeps status", st[31], 0);
            request(1'b1);
            chk(rsp_valid && rsp_avail && !rsp_dropped, "R4", "take response",
                {rsp_valid, rsp_avail, rsp_dropped}, 6);
            chk(rsp_len == 14'(eff), (lens[i] > BB) ? "R7" : "R4", "take length", rsp_len, eff);
            consume(slot, eff);
            exp_tail = (exp_tail + 1) % NS;
            check_returned(slot, "R5");
        end

        // R7: zero length frame returns at once
        slot = exp_tail;
        dev_status(slot, 32'h0000_0000);
        request(1'b1);
        chk(rsp_valid && rsp_avail && rsp_len == 0, "R7", "zero length response", rsp_len, 0);
        chk(!out_valid, "R7", "zero length streams nothing", out_valid, 0);
        exp_tail = (exp_tail + 1) % NS;
        check_returned(slot, "R7");

        // R6: errored frame is dropped
        slot = exp_tail;
        fill(slot, 8);
        dev_status(slot, 32'h0064_8000);
        request(1'b0);
        chk(rsp_avail, "R3", "query reports errored slot pending", rsp_avail, 1);
        request(1'b1);
        chk(rsp_valid && !rsp_avail && rsp_dropped, "R6", "drop response",
            {rsp_valid, rsp_avail, rsp_dropped}, 5);
        chk(!out_valid, "R6", "drop streams nothing", out_valid, 0);
        exp_tail = (exp_tail + 1) % NS;
        check_returned(slot, "R6");

        // R9: illegal device writes to a host-owned slot
        chk(!proto_err, "R9", "no error yet", proto_err, 0);
        slot = exp_tail;
        fill(slot, 8);
        dev_status(slot, 32'h0008_0000);
        dev_status(slot, 32'h0123_0000);
        @(negedge clk);
        read_status(slot, st);
        chk(st == 32'h0008_0000, "R9", "status write ignored", st, 32'h0008_0000);
        chk(proto_err, "R9", "error after status write", proto_err, 1);
        dev_word(slot, 0, 32'hDEAD_BEEF);
        @(negedge clk);
        request(1'b1);
        chk(rsp_avail && rsp_len == 8, "R9", "frame intact", rsp_len, 8);
        consume(slot, 8);
        exp_tail = (exp_tail + 1) % NS;
        check_returned(slot, "R5");
        chk(proto_err, "R9", "error sticky", proto_err, 1);

        done = 1'b1;
        finish_run();
    end
endmodule